// File: doc/BRIEF.md
# Register Pointer Sequencer with Auto-Increment Windows

This block keeps the pointer that selects which register of a serial-bus peripheral is being read or written. The first data byte after an address match is a control byte. Its low five bits give the starting register index and its upper three bits pick how the index moves. After that, every completed data byte can step the index. Depending on the mode, the index stays put, walks the whole register map, or cycles inside a smaller window that has its own upper limit and its own restart point.

The bus engine raises a one-cycle load strobe with the control byte, and a one-cycle strobe at the end of each data byte. The register file uses the index that comes out. The data held in the registers is outside this block.

Top module: `regptr_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the index to 00h and the mode to 000. Reset takes priority over every other input. Directly after reset, a byte-done strobe leaves the index at 00h.
- R2: When `ctl_wr` is sampled high, the next cycle shows `reg_index` equal to `ctl_byte[4:0]`. From then on, `ctl_byte[7:5]` is the active mode.
- R3: While mode bit 7 is 0 (modes 000, 001, 010 and 011), a byte-done strobe leaves the index unchanged.
- R4: In mode 100, a byte-done strobe adds one to the index, and index 1Bh goes to 00h.
- R5: In mode 101, the index goes from 11h to 02h. Below 11h it adds one.
- R6: In mode 110, the index goes from 13h to 12h.
- R7: In mode 111, the index goes from 13h to 02h. Control byte F4h gives 14h..1Bh, then 00h..13h, then 02h..13h repeated.
- R8: In any increment mode, an index below the window limit adds one. An index above the limit climbs to 1Bh and then goes to 00h. An index of 1Ch..1Fh (reachable only by loading it) adds one, and 1Fh goes to 00h.
- R9: When `ctl_wr` and `byte_done` occur in the same cycle, the load wins. The index takes the new pointer without a step.
- R10: With neither strobe high, the index holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | One-cycle strobe: load `ctl_byte` as the new control byte |
| ctl_byte | input | 8 | Control byte: [7:5] increment mode, [4:0] start index |
| byte_done | input | 1 | One-cycle strobe: a data byte has been read or written |
| reg_index | output | 5 | Current register index |

## Verification
The assertions assume that the strobes are single-cycle pulses, already synchronous to `clk`, and that `ctl_byte` is valid whenever `ctl_wr` is high. The assertions do not depend on the bus engine spacing its strobes apart.

The stimulus drives every input half a cycle away from the active edge. It covers all eight mode codes, loads pointers inside, below and above each window, and includes one cycle with both strobes at once and one cycle with reset alongside a load. It never depends on the value of `ctl_byte` while `ctl_wr` is low.

// File: rtl/regptr_pkg.sv
package regptr_pkg;

    localparam int PTR_W  = 5;
    localparam int MODE_W = 3;
    localparam int CTL_W  = PTR_W + MODE_W;

    typedef logic [PTR_W-1:0] ptr_t;

    // Increment mode codes carried in the top three control bits
    typedef enum logic [MODE_W-1:0] {
        AI_OFF    = 3'b000,
        AI_RSV_A  = 3'b001,
        AI_RSV_B  = 3'b010,
        AI_RSV_C  = 3'b011,
        AI_ALL    = 3'b100,
        AI_BRIGHT = 3'b101,
        AI_GROUP  = 3'b110,
        AI_MIXED  = 3'b111
    } ai_mode_e;

    // Register map landmarks
    localparam ptr_t IDX_FIRST  = 5'h00;
    localparam ptr_t IDX_LAST   = 5'h1B;
    localparam ptr_t BRIGHT_LO  = 5'h02;
    localparam ptr_t BRIGHT_HI  = 5'h11;
    localparam ptr_t GROUP_LO   = 5'h12;
    localparam ptr_t GROUP_HI   = 5'h13;

    // Stored control byte, mode above pointer
    typedef struct packed {
        ai_mode_e mode;
        ptr_t     ptr;
    } ctl_t;

    // Window chosen by the mode
    typedef struct packed {
        logic active;
        ptr_t limit;
        ptr_t target;
    } window_t;

    function automatic window_t window_of(input ai_mode_e m);
        window_t w;
        w.active = 1'b1;
        w.limit  = IDX_LAST;
        w.target = IDX_FIRST;
        case (m)
            AI_ALL: begin
                w.limit  = IDX_LAST;
                w.target = IDX_FIRST;
            end
            AI_BRIGHT: begin
                w.limit  = BRIGHT_HI;
                w.target = BRIGHT_LO;
            end
            AI_GROUP: begin
                w.limit  = GROUP_HI;
                w.target = GROUP_LO;
            end
            AI_MIXED: begin
                w.limit  = GROUP_HI;
                w.target = BRIGHT_LO;
            end
            default: begin
                w.active = 1'b0;
            end
        endcase
        return w;
    endfunction

    function automatic ptr_t advance(input ptr_t p, input window_t w);
        ptr_t n;
        if (!w.active)
            n = p;
        else if (p == w.limit)
            n = w.target;
        else if (p == IDX_LAST)
            n = IDX_FIRST;
        else
            n = p + ptr_t'(1);
        return n;
    endfunction

endpackage

// File: rtl/regptr_ctl_reg.sv
module regptr_ctl_reg
    import regptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CTL_W-1:0] byte_in,
    input  logic             step,
    input  ptr_t             ptr_next,
    output ctl_t             ctl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.mode <= AI_OFF;
            ctl_q.ptr  <= IDX_FIRST;
        end else if (load) begin
            ctl_q <= ctl_t'(byte_in);
        end else if (step) begin
            ctl_q.ptr <= ptr_next;
        end
    end

endmodule

// File: rtl/regptr_window.sv
module regptr_window
    import regptr_pkg::*;
(
    input  ai_mode_e mode,
    output window_t  win
);

    always_comb begin
        win = window_of(mode);
    end

endmodule

// File: rtl/regptr_step.sv
module regptr_step
    import regptr_pkg::*;
(
    input  ptr_t    ptr_cur,
    input  window_t win,
    output ptr_t    ptr_next
);

    always_comb begin
        ptr_next = advance(ptr_cur, win);
    end

endmodule

// File: rtl/regptr_seq.sv
module regptr_seq
    import regptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_byte,
    input  logic             byte_done,
    output logic [PTR_W-1:0] reg_index
);

    ctl_t                    ctl_q;
    window_t                 win;
    ptr_t                    ptr_next;
    logic [MODE_W-1:0]       cur_mode;

    regptr_ctl_reg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl_wr),
        .byte_in  (ctl_byte),
        .step     (byte_done),
        .ptr_next (ptr_next),
        .ctl_q    (ctl_q)
    );

    regptr_window u_win (
        .mode (ctl_q.mode),
        .win  (win)
    );

    regptr_step u_step (
        .ptr_cur  (ctl_q.ptr),
        .win      (win),
        .ptr_next (ptr_next)
    );

    assign cur_mode  = ctl_q.mode;
    assign reg_index = ctl_q.ptr;

endmodule

// File: rtl/regptr_chk.sv
module regptr_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic [7:0] ctl_byte,
    input logic       byte_done,
    input logic [4:0] reg_index,
    input logic [2:0] mode
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (reg_index == 5'h00 && mode == 3'b000));

    a_r2_load_ptr: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (reg_index == $past(ctl_byte[4:0]) && mode == $past(ctl_byte[7:5])));

    a_r3_no_auto_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl_wr && byte_done && !mode[2]) |=> $stable(reg_index));

    a_r4_all_wrap: assert property (@(posedge clk) disable iff (rst)
        (!ctl_wr && byte_done && mode == 3'b100 && reg_index == 5'h1B) |=> reg_index == 5'h00);

    a_r5_bright_wrap: assert property (@(posedge clk) disable iff (rst)
        (!ctl_wr && byte_done && mode == 3'b101 && reg_index == 5'h11) |=> reg_index == 5'h02);

    a_r6_group_wrap: assert property (@(posedge clk) disable iff (rst)
        (!ctl_wr && byte_done && mode == 3'b110 && reg_index == 5'h13) |=> reg_index == 5'h12);

    a_r7_mixed_wrap: assert property (@(posedge clk) disable iff (rst)
        (!ctl_wr && byte_done && mode == 3'b111 && reg_index == 5'h13) |=> reg_index == 5'h02);

    a_r8_step_below: assert property (@(posedge clk) disable iff (rst)
        (!ctl_wr && byte_done && mode[2] && reg_index < 5'h11)
        |=> reg_index == $past(reg_index) + 5'd1);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl_wr && !byte_done) |=> ($stable(reg_index) && $stable(mode)));

endmodule

bind regptr_seq regptr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ctl_byte  (ctl_byte),
    .byte_done (byte_done),
    .reg_index (reg_index),
    .mode      (cur_mode)
);

// File: tb/sim_regptr_seq.sv
`timescale 1ns/1ps
module sim_regptr_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_byte = 8'h00;
    logic       byte_done = 1'b0;
    logic [4:0] reg_index;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    regptr_seq u0 (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_byte  (ctl_byte),
        .byte_done (byte_done),
        .reg_index (reg_index)
    );

    // op: 0 idle, 1 load, 2 byte done, 3 load and byte done together
    typedef struct packed {
        logic [1:0] op;
        logic [7:0] data;
        logic [4:0] expect_idx;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'h00, 5'h00, 4'd1},   // R1 reset value holds
        '{2'd2, 8'h00, 5'h00, 4'd1},   // R1 mode cleared: no step
        '{2'd1, 8'h05, 5'h05, 4'd2},   // R2
        '{2'd2, 8'h00, 5'h05, 4'd3},   // R3 mode 000
        '{2'd1, 8'h27, 5'h07, 4'd2},   // R2
        '{2'd2, 8'h00, 5'h07, 4'd3},   // R3 mode 001
        '{2'd1, 8'h4A, 5'h0A, 4'd2},   // R2
        '{2'd2, 8'h00, 5'h0A, 4'd3},   // R3 mode 010
        '{2'd1, 8'h70, 5'h10, 4'd2},   // R2
        '{2'd2, 8'h00, 5'h10, 4'd3},   // R3 mode 011
        '{2'd1, 8'h9A, 5'h1A, 4'd2},   // R2
        '{2'd2, 8'h00, 5'h1B, 4'd4},   // R4
        '{2'd2, 8'h00, 5'h00, 4'd4},   // R4 wrap
        '{2'd2, 8'h00, 5'h01, 4'd4},   // R4
        '{2'd1, 8'hB0, 5'h10, 4'd2},   // R2
        '{2'd2, 8'h00, 5'h11, 4'd5},   // R5
        '{2'd2, 8'h00, 5'h02, 4'd5},   // R5 wrap
        '{2'd2, 8'h00, 5'h03, 4'd5},   // R5
        '{2'd1, 8'hD2, 5'h12, 4'd2},   // R2
        '{2'd2, 8'h00, 5'h13, 4'd6},   // R6
        '{2'd2, 8'h00, 5'h12, 4'd6},   // R6 wrap
        '{2'd2, 8'h00, 5'h13, 4'd6},   // R6
        '{2'd1, 8'hF2, 5'h12, 4'd2},   // R2
        '{2'd2, 8'h00, 5'h13, 4'd7},   // R7
        '{2'd2, 8'h00, 5'h02, 4'd7},   // R7 wrap
        '{2'd2, 8'h00, 5'h03, 4'd7},   // R7
        '{2'd1, 8'hFA, 5'h1A, 4'd8},   // R8 above limit
        '{2'd2, 8'h00, 5'h1B, 4'd8},   // R8
        '{2'd2, 8'h00, 5'h00, 4'd8},   // R8 last register wraps
        '{2'd1, 8'hC5, 5'h05, 4'd8},   // R8 below window
        '{2'd2, 8'h00, 5'h06, 4'd8},   // R8
        '{2'd1, 8'h9F, 5'h1F, 4'd8},   // R8 top code
        '{2'd2, 8'h00, 5'h00, 4'd8},   // R8 1F to 00
        '{2'd1, 8'hBD, 5'h1D, 4'd8},   // R8 flag area
        '{2'd2, 8'h00, 5'h1E, 4'd8},   // R8
        '{2'd2, 8'h00, 5'h1F, 4'd8},   // R8
        '{2'd2, 8'h00, 5'h00, 4'd8},   // R8
        '{2'd1, 8'h83, 5'h03, 4'd2},   // R2
        '{2'd0, 8'h00, 5'h03, 4'd10},  // R10
        '{2'd0, 8'h00, 5'h03, 4'd10},  // R10
        '{2'd3, 8'h0C, 5'h0C, 4'd9},   // R9 load wins
        '{2'd2, 8'h00, 5'h0C, 4'd9},   // R9 new mode 000 took effect
        '{2'd1, 8'hA1, 5'h01, 4'd2},   // R2
        '{2'd2, 8'h00, 5'h02, 4'd5}    // R5 step below limit
    };

    // Called at a falling edge; returns at the next falling edge
    task automatic drive(input logic [1:0] op, input logic [7:0] d);
        ctl_wr    = op[0];
        byte_done = op[1];
        ctl_byte  = d;
        @(negedge clk);
        ctl_wr    = 1'b0;
        byte_done = 1'b0;
        ctl_byte  = 8'h00;
    endtask

    task automatic check(input logic [4:0] exp_idx, input int req, input string what);
        tests++;
        if (reg_index !== exp_idx) begin
            fails++;
            $display("FAIL R%0d %s: reg_index=%02h expected=%02h", req, what, reg_index, exp_idx);
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check(5'h00, 1, "index during reset");   // R1
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].data);
            check(VEC[i].expect_idx, int'(VEC[i].req), $sformatf("vector %0d", i));
        end

        // R7 / R8: control byte F4h walks 14..1B, 00..13, then 02..13 repeatedly
        begin
            logic [4:0] e;
            drive(2'd1, 8'hF4);
            e = 5'h14;
            check(e, 7, "F4 start");
            for (int k = 0; k < 60; k++) begin
                if (e == 5'h1B)      e = 5'h00;
                else if (e == 5'h13) e = 5'h02;
                else                 e = e + 5'd1;
                drive(2'd2, 8'h00);
                check(e, 7, $sformatf("F4 walk step %0d", k));
            end
        end

        // R1: reset together with a load and a step
        drive(2'd1, 8'h9A);
        check(5'h1A, 2, "load before reset");
        rst = 1'b1;
        drive(2'd3, 8'hFF);
        rst = 1'b0;
        check(5'h00, 1, "reset beats load");
        drive(2'd2, 8'h00);
        check(5'h00, 1, "mode cleared by reset");

        // R10: idle after a load in an increment mode
        drive(2'd1, 8'hE9);
        drive(2'd0, 8'h00);
        check(5'h09, 10, "idle after load");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: reg_index=%02h expected=completion", reg_index);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule